// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This peripheral supervises software through a two-word register window. Software writes a tick count into the timer word. Once a non-zero expiry action is selected in the control word, the count falls by one on every clock. If software does not write a fresh count before it reaches zero, the block takes the selected action. The action can be nothing, a level interrupt, a level non-maskable interrupt, or a single-cycle request to the chip's reset generator.

A new count becomes active a fixed number of cycles after the write is accepted. Software reads the timer word back to flush its write, then waits out that latency before it arms the watchdog. Both words can be read at any time.

A sticky flag records that the watchdog requested a chip reset. The functional reset `rst_ni` does not clear it, so it survives the reset the watchdog itself caused. Only the power-on reset `por_ni` clears it. Software reads the flag in the top bit of the control word.

Top module: `expiry_watchdog`

## Requirements
- R1: After reset with both reset inputs asserted, the control word reads 0, the timer word reads 0, and `irq_o`, `nmi_o` and `chip_rst_req_o` are low.
- R2: The control word is at byte offset 0x00. Bits [1:0] hold the action code: 0 none, 1 interrupt, 2 NMI, 3 chip reset. Writes to bits [31:2] are ignored. Bits [30:2] always read as zero.
- R3: The timer word is at byte offset 0x04 and reads back the active count. A value written there becomes the active count LOAD_LAT cycles after the write edge (default 3). Before that, the old count still reads back.
- R4: The count falls by one per clock only while the action code is non-zero. With action 0 it holds its value and no output is ever raised.
- R5: With action 1, `irq_o` rises N+1 cycles after arming a loaded count N. It stays high until the timer word is written, and it falls on the edge that accepts that write.
- R6: With action 2, `nmi_o` behaves like `irq_o` in R5, with the same timing and the same level hold.
- R7: With action 3, `chip_rst_req_o` is high for exactly one cycle, N+1 cycles after arming a loaded count N.
- R8: After an expiry the count stays at zero. No action fires again until a new count has been loaded.
- R9: The control word's bit 31 reads 1 after a chip-reset expiry. It keeps that value through `rst_ni` and is cleared only by `por_ni`.
- R10: Writing the timer word while the count is running restarts the timeout from the new value. No expiry comes from the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous functional reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears the sticky flag |
| addr_i | input | AW | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt on expiry with action 1 |
| nmi_o | output | 1 | Level NMI on expiry with action 2 |
| chip_rst_req_o | output | 1 | One-cycle chip reset request on expiry with action 3 |

## Verification
The assertions check the following on every cycle:
- the count holds with action 0 and stays at zero once it has reached zero;
- the reset request is never longer than one cycle;
- the interrupt and NMI levels persist until a timer write;
- at most one action output is high at a time;
- the sticky flag is set with every reset request and never drops without a power-on reset.

The exact cycle counts need the bench's scenarios:
- the load latency;
- the N+1 expiry delay;
- a refresh that beats an expiry;
- the readback values, including the ignored control bits and the flag surviving a functional reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_NMI   = 2'd2,
    ACT_RESET = 2'd3
  } act_e;

  localparam int unsigned CTRL_WORD  = 0;
  localparam int unsigned TIMER_WORD = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          flag_i,
  output act_e          act_o,
  output logic          tmr_wr_o,
  output logic [DW-1:0] tmr_wdata_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned WW = AW - 2;

  logic          aligned;
  logic [WW-1:0] word;
  logic          ctrl_sel, tmr_sel;
  act_e          act_q;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign word     = addr_i[AW-1:2];
  assign ctrl_sel = aligned && (word == WW'(CTRL_WORD));
  assign tmr_sel  = aligned && (word == WW'(TIMER_WORD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  act_q <= ACT_NONE;
    else if (wr_en_i && ctrl_sel) act_q <= act_e'(wdata_i[1:0]);
  end

  assign act_o       = act_q;
  assign tmr_wr_o    = wr_en_i && tmr_sel;
  assign tmr_wdata_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel)     rdata_o = {flag_i, {(DW-3){1'b0}}, act_q};
    else if (tmr_sel) rdata_o = cnt_i;
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  act_e          act_i,
  input  logic          tmr_wr_i,
  input  logic [DW-1:0] tmr_wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic          pend_o,
  output logic          expire_o
);
  localparam int unsigned LW = (LOAD_LAT > 0) ? $clog2(LOAD_LAT + 1) : 1;

  logic          load;
  logic [DW-1:0] load_val;
  logic [DW-1:0] cnt_q;
  logic          fired_q;

  generate
    if (LOAD_LAT == 0) begin : g_direct
      assign load     = tmr_wr_i;
      assign load_val = tmr_wdata_i;
      assign pend_o   = 1'b0;
    end else begin : g_delayed
      logic [LW-1:0] lat_q;
      logic [DW-1:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lat_q <= '0;
          val_q <= '0;
        end else if (tmr_wr_i) begin
          lat_q <= LW'(LOAD_LAT);
          val_q <= tmr_wdata_i;
        end else if (lat_q != '0) begin
          lat_q <= lat_q - 1'b1;
        end
      end
      assign load     = (lat_q == LW'(1));
      assign load_val = val_q;
      assign pend_o   = (lat_q != '0);
    end
  endgenerate

  // an in-flight refresh suppresses expiry
  assign expire_o = (act_i != ACT_NONE) && (cnt_q == '0) && !fired_q
                    && !pend_o && !tmr_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (load)                                cnt_q <= load_val;
    else if (act_i != ACT_NONE && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fired_q <= 1'b0;
    else if (load)     fired_q <= 1'b0;
    else if (expire_o) fired_q <= 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  act_e act_i,
  input  logic expire_i,
  input  logic tmr_wr_i,
  output logic irq_o,
  output logic nmi_o,
  output logic rst_req_o,
  output logic flag_o
);
  logic irq_q, nmi_q, req_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire_i && (act_i == ACT_RESET);
      if (expire_i && act_i == ACT_IRQ) irq_q <= 1'b1;
      else if (tmr_wr_i)                irq_q <= 1'b0;
      if (expire_i && act_i == ACT_NMI) nmi_q <= 1'b1;
      else if (tmr_wr_i)                nmi_q <= 1'b0;
    end
  end

  // survives functional reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                                flag_q <= 1'b0;
    else if (expire_i && act_i == ACT_RESET)    flag_q <= 1'b1;
  end

  assign irq_o     = irq_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = req_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned LOAD_LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          nmi_o,
  output logic          chip_rst_req_o
);
  act_e          act_w;
  logic          tmr_wr_w;
  logic [DW-1:0] tmr_wdata_w;
  logic [DW-1:0] cnt_w;
  logic          pend_w;
  logic          expire_w;
  logic          flag_w;

  wdt_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .cnt_i       (cnt_w),
    .flag_i      (flag_w),
    .act_o       (act_w),
    .tmr_wr_o    (tmr_wr_w),
    .tmr_wdata_o (tmr_wdata_w),
    .rdata_o     (rdata_o)
  );

  wdt_timer #(.DW(DW), .LOAD_LAT(LOAD_LAT)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_w),
    .tmr_wr_i    (tmr_wr_w),
    .tmr_wdata_i (tmr_wdata_w),
    .cnt_o       (cnt_w),
    .pend_o      (pend_w),
    .expire_o    (expire_w)
  );

  wdt_action u_action (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .por_ni    (por_ni),
    .act_i     (act_w),
    .expire_i  (expire_w),
    .tmr_wr_i  (tmr_wr_w),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (chip_rst_req_o),
    .flag_o    (flag_w)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          por_ni,
  input logic [1:0]    act,
  input logic          tmr_wr,
  input logic          pend,
  input logic [DW-1:0] cnt,
  input logic          flag,
  input logic          irq,
  input logic          nmi,
  input logic          rst_req
);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == 2'd0 && !pend && !tmr_wr) |=> $stable(cnt));

  p_irq_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !tmr_wr) |=> irq);

  p_nmi_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi && !tmr_wr) |=> nmi);

  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> !rst_req);

  p_stay_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !pend && !tmr_wr) |=> (cnt == '0));

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_req |-> flag);

  p_flag_keep_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    flag |=> flag);

  p_one_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq, nmi, rst_req}));
endmodule

bind expiry_watchdog wdt_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .por_ni  (por_ni),
  .act     (act_w),
  .tmr_wr  (tmr_wr_w),
  .pend    (pend_w),
  .cnt     (cnt_w),
  .flag    (flag_w),
  .irq     (irq_o),
  .nmi     (nmi_o),
  .rst_req (chip_rst_req_o)
);

// File: tb/sim_expiry_watchdog.sv
module sim_expiry_watchdog;
  localparam int unsigned AW  = 4;
  localparam int unsigned DW  = 32;
  localparam int unsigned LAT = 3;
  localparam logic [AW-1:0] A_CTRL = 4'h0;
  localparam logic [AW-1:0] A_TMR  = 4'h4;

  // {action, count, expected {irq,nmi,req}}
  localparam int NV = 6;
  localparam logic [36:0] VECS [NV] = '{
    {2'd1, 32'd5, 3'b100},
    {2'd2, 32'd3, 3'b010},
    {2'd3, 32'd4, 3'b001},
    {2'd1, 32'd0, 3'b100},
    {2'd0, 32'd4, 3'b000},
    {2'd2, 32'd1, 3'b010}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          por_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, nmi, req;
  int            total = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  expiry_watchdog #(.AW(AW), .DW(DW), .LOAD_LAT(LAT)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .por_ni         (por_ni),
    .addr_i         (addr),
    .wr_en_i        (wr_en),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .irq_o          (irq),
    .nmi_o          (nmi),
    .chip_rst_req_o (req)
  );

  task automatic chk(input string req_id, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req_id, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic reset_core();
    rst_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic reset_all();
    rst_ni = 1'b0; por_ni = 1'b0;
    tick(2);
    rst_ni = 1'b1; por_ni = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, v2;
    @(negedge clk);
    reset_all();

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_TMR, v);  chk("R1 timer", v, 0);
    chk("R1 outputs", {29'd0, irq, nmi, req}, 0);

    // table walk: load, arm, expect expiry at N+1
    for (int i = 0; i < NV; i++) begin
      logic [1:0]    va;
      logic [31:0]   vn;
      logic [2:0]    ve;
      string         tag;
      {va, vn, ve} = VECS[i];
      tag = (va == 2'd1) ? "R5" : (va == 2'd2) ? "R6" : (va == 2'd3) ? "R7" : "R4";
      reset_core();
      wr(A_TMR, vn);
      tick(LAT);
      wr(A_CTRL, {30'd0, va});
      if (vn != 0) begin
        tick(vn);
        chk({tag, " before expiry"}, {29'd0, irq, nmi, req}, 0);
        tick(1);
      end else begin
        tick(1);
      end
      chk({tag, " at expiry"}, {29'd0, irq, nmi, req}, {29'd0, ve});
      tick(1);
      chk({tag, " after expiry"}, {29'd0, irq, nmi, req}, {29'd0, ve & 3'b110});
      if (va == 2'd0) begin
        rd(A_TMR, v); chk("R4 idle count held", v, vn);
      end
    end

    // R3 load latency
    reset_all();
    wr(A_TMR, 32'd77);
    tick(LAT - 1);
    rd(A_TMR, v); chk("R3 old count before latency", v, 0);
    tick(1);
    rd(A_TMR, v); chk("R3 new count after latency", v, 77);

    // R4 held while disarmed
    tick(10);
    rd(A_TMR, v); chk("R4 held with action 0", v, 77);

    // R2 reserved bits ignored
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, v); chk("R2 only action field kept", v, 32'h2);
    tick(5);
    rd(A_TMR, v); chk("R4 decrements when armed", v, 72);
    wr(A_CTRL, 32'h0000_0004);
    rd(A_CTRL, v); chk("R2 bit 2 ignored", v, 0);
    rd(A_TMR, v);
    tick(5);
    rd(A_TMR, v2); chk("R4 stops after disarm", v2, v);

    // R10 refresh beats expiry
    reset_core();
    wr(A_TMR, 32'd10);
    tick(LAT);
    wr(A_CTRL, 32'd1);
    tick(6);
    wr(A_TMR, 32'd10);
    tick(7);
    chk("R10 no expiry from old count", {31'd0, irq}, 0);
    tick(6);
    chk("R10 no early expiry", {31'd0, irq}, 0);
    tick(1);
    chk("R10 expiry from new count", {31'd0, irq}, 1);

    // R5 timer write clears level
    tick(3);
    chk("R5 level held", {31'd0, irq}, 1);
    wr(A_TMR, 32'd50);
    chk("R5 cleared by timer write", {31'd0, irq}, 0);

    // R7, R8, R9 chip reset path and sticky flag
    reset_core();
    wr(A_TMR, 32'd3);
    tick(LAT);
    wr(A_CTRL, 32'd3);
    tick(4);
    chk("R7 reset request pulse", {31'd0, req}, 1);
    for (int k = 0; k < 10; k++) begin
      tick(1);
      chk("R8 no refire", {29'd0, irq, nmi, req}, 0);
    end
    rd(A_TMR, v);  chk("R8 count parked at zero", v, 0);
    rd(A_CTRL, v); chk("R9 flag set", v, 32'h8000_0003);
    reset_core();
    rd(A_CTRL, v); chk("R9 flag survives functional reset", v, 32'h8000_0000);
    reset_all();
    rd(A_CTRL, v); chk("R9 flag cleared by power-on reset", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule